// File: doc/BRIEF.md
# I2C Master Clock Generator with Acknowledge Control

This block produces the SCL waveform for one byte of an I2C transfer. It runs from a 4 MHz reference clock and is set up through one 8-bit configuration word. A start strobe from the byte engine begins a byte. The block then issues eight data clock pulses and, when enabled, a ninth acknowledge pulse. A done pulse marks the end of the byte and carries the acknowledge level seen on SDA.

The SCL period depends on a 5-bit divider code and a mode bit. In standard mode the period is code×8 reference cycles. In fast mode it is code×4 cycles, except for fast code 5, which gives a 10-cycle period with 6 cycles low and 4 high. During the acknowledge pulse the block drives SDA as an open-drain line. It pulls SDA low when it acts as a receiver that acknowledges. For an address byte it pulls SDA low only when the address matched. Otherwise it releases SDA and samples the line. Writing the configuration word aborts any byte in progress.

Top module: `scl_gen`

## Requirements
- R1: The configuration word holds the divider code in bits [4:0], fast mode in bit 5 (1 = fast), the acknowledge-drive bit in bit 6 (0 = acknowledge, 1 = hold SDA released) and the acknowledge-clock enable in bit 7. All bits are 0 after reset, so after reset the error flag is 1 and SCL is high.
- R2: In standard mode (bit 5 = 0) with code 5..31, one SCL pulse lasts code×8 cycles: code×4 cycles low followed by code×4 cycles high.
- R3: In fast mode with code 3, 4 or 6..31, one SCL pulse lasts code×4 cycles: code×2 cycles low followed by code×2 cycles high.
- R4: In fast mode with code 5, one SCL pulse lasts 10 cycles: 6 cycles low followed by 4 cycles high.
- R5: Codes 0..4 in standard mode and codes 0..2 in fast mode raise `cfg_err`. While it is raised, a start is ignored, SCL stays high, and no busy or done is produced.
- R6: SCL idles high. A byte produces 8 SCL pulses when the acknowledge-clock enable is 0 and 9 pulses when it is 1.
- R7: In transmit mode (`rx_mode` = 0), SDA is never pulled low. The SDA level sampled in the acknowledge pulse is returned on `ack_o`. Without an acknowledge pulse, `ack_o` is 1.
- R8: In receive mode with `addr_byte` = 0, SDA is pulled low during the acknowledge pulse exactly when the acknowledge-drive bit is 0.
- R9: In receive mode with `addr_byte` = 1, SDA is pulled low during the acknowledge pulse only when the acknowledge-drive bit is 0 and `addr_match` is 1.
- R10: A configuration write during a byte ends it at once: `busy_o` drops, SCL goes high, and no done pulse follows.
- R11: `done_o` is a single-cycle pulse. It appears pulses×period cycles after the cycle in which the start was taken.
- R12: While a byte is running, the SDA pull-down does not change while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word |
| start_i | input | 1 | Begin one byte |
| rx_mode | input | 1 | 1 = block receives the byte, 0 = transmits |
| addr_byte | input | 1 | Current byte is an address byte |
| addr_match | input | 1 | Own address matched the received address |
| sda_in | input | 1 | Level seen on the SDA line |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| busy_o | output | 1 | A byte is in progress |
| done_o | output | 1 | One-cycle end-of-byte pulse |
| ack_o | output | 1 | SDA level sampled in the acknowledge pulse |
| cfg_err | output | 1 | Divider code is forbidden for the selected mode |

## Verification
The hardest condition to reach is the acknowledge slot, where the SDA pull-down depends on the transfer direction, the byte type, the address match and the acknowledge-drive bit together. The bench models the open-drain bus: the line is low if the block or a modelled slave pulls it low. It walks these combinations at a fixed code. For each combination it records the pull-down in each SCL phase and the level returned with done. The timing sweep covers every code in both modes, and the acknowledge-clock enable alternates with the code's low bit.

// File: rtl/scl_gen.sv
module scl_gen #(
  parameter int CODE_W     = 5,
  parameter int BITS       = 8,
  parameter int STD_MULT   = 8,
  parameter int FAST_MULT  = 4,
  parameter int STD_MIN    = 5,
  parameter int FAST_MIN   = 3,
  parameter int SPEC_CODE  = 5,
  parameter int SPEC_PER   = 10,
  parameter int SPEC_LOW   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       start_i,
  input  logic       rx_mode,
  input  logic       addr_byte,
  input  logic       addr_match,
  input  logic       sda_in,
  output logic       scl_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ack_o,
  output logic       cfg_err
);
  localparam int PW = CODE_W + $clog2(STD_MULT) + 1;
  localparam int IW = $clog2(BITS + 1);

  logic [CODE_W-1:0] code;
  logic              fast, nack, ack_en;
  logic [PW-1:0]     period, low_t, cnt;
  logic [IW-1:0]     bit_idx, last_bit;
  logic              in_slot;

  wire [PW-1:0] code_x = PW'(code);

  always_comb begin
    if (fast && code == CODE_W'(SPEC_CODE)) begin
      period = PW'(SPEC_PER);
      low_t  = PW'(SPEC_LOW);
    end else begin
      period = fast ? code_x * PW'(FAST_MULT) : code_x * PW'(STD_MULT);
      low_t  = period >> 1;
    end
  end

  assign cfg_err   = fast ? (code < CODE_W'(FAST_MIN)) : (code < CODE_W'(STD_MIN));
  assign last_bit  = ack_en ? IW'(BITS) : IW'(BITS - 1);
  assign in_slot   = busy_o && ack_en && bit_idx == IW'(BITS);
  assign scl_o     = !(busy_o && cnt < low_t);
  assign sda_low_o = in_slot && rx_mode && !nack && (!addr_byte || addr_match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ack_en, nack, fast, code} <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      ack_o   <= 1'b1;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      done_o <= 1'b0;
      if (cfg_we) begin
        {ack_en, nack, fast, code} <= cfg_wdata;
        busy_o  <= 1'b0;
        cnt     <= '0;
        bit_idx <= '0;
      end else if (!busy_o) begin
        if (start_i && !cfg_err) begin
          busy_o  <= 1'b1;
          cnt     <= '0;
          bit_idx <= '0;
          ack_o   <= 1'b1;
        end
      end else begin
        if (in_slot && cnt == low_t)
          ack_o <= sda_in;
        if (cnt == period - 1'b1) begin
          cnt <= '0;
          if (bit_idx == last_bit) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !busy_o |=> !busy_o && scl_o);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !busy_o && !done_o && scl_o);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o) && !busy_o);
  a_r12_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && scl_o && $past(scl_o) |-> $stable(sda_low_o));
  a_r7_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode |-> !sda_low_o);
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> scl_o);
endmodule

// File: tb/test_scl_gen.sv
module test_scl_gen;
  localparam int CLK_NS = 250;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, start_i = 0, rx_mode = 0, addr_byte = 0, addr_match = 0;
  logic [7:0] cfg_wdata = '0;
  logic slave_sda = 1;
  logic scl_o, sda_low_o, busy_o, done_o, ack_o, cfg_err;
  wire sda_in = slave_sda & ~sda_low_o;

  int total = 0, bad = 0, cycles = 0;
  int low1, high1, rises, n, slot_low, slot_cycles, stray, unstable, got_ack;
  bit timed_out;

  scl_gen i_scl_gen (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start_i(start_i), .rx_mode(rx_mode), .addr_byte(addr_byte), .addr_match(addr_match),
    .sda_in(sda_in), .scl_o(scl_o), .sda_low_o(sda_low_o), .busy_o(busy_o),
    .done_o(done_o), .ack_o(ack_o), .cfg_err(cfg_err));

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run_byte();
    bit prev, s, ps;
    ps = 0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    prev = 1; rises = 0; n = 0; low1 = 0; high1 = 0;
    slot_low = 0; slot_cycles = 0; stray = 0; unstable = 0; timed_out = 0;
    forever begin
      if (n > 0) @(negedge clk);
      if (done_o) break;
      n++;
      s = scl_o;
      if (!prev && s) rises++;
      if (rises == 0 && !s) low1++;
      if (rises == 1 && s) high1++;
      if (rises == 9 || (rises == 8 && !s)) begin
        slot_cycles++;
        if (sda_low_o) slot_low++;
      end else if (sda_low_o) stray++;
      if (s && prev && n > 1 && sda_low_o != ps) unstable++;
      prev = s; ps = sda_low_o;
      if (n > 5000) begin timed_out = 1; break; end
    end
    got_ack = ack_o;
    @(negedge clk);
    check("R11 done single cycle", done_o, 0);
  endtask

  task automatic slot_case(input string req, input bit rx, input bit ab, input bit am,
                           input bit nk, input bit sl, input int exp_low, input int exp_ack);
    rx_mode = rx; addr_byte = ab; addr_match = am; slave_sda = sl;
    write_cfg({1'b1, nk, 1'b0, 5'd5});
    run_byte();
    check({req, " pull-down through ack pulse"}, slot_low, exp_low ? slot_cycles : 0);
    check({req, " no stray pull-down"}, stray, 0);
    check({req, " ack level"}, got_ack, exp_ack);
    check("R12 SDA stable while SCL high", unstable, 0);
  endtask

  initial begin
    #(CLK_NS*3);
    check("R1 reset err flag", cfg_err, 1);
    check("R1 reset scl high", scl_o, 1);
    check("R1 reset busy", busy_o, 0);
    @(negedge clk); rst_n = 1;

    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 32; c++) begin
        int per, lo, np;
        bit ae, err;
        ae = c[0];
        err = m ? (c < 3) : (c < 5);
        write_cfg({ae, 1'b1, m[0], c[4:0]});
        check("R5 error flag", cfg_err, err);
        if (err) begin
          int busy_seen = 0, low_seen = 0, done_seen = 0;
          @(negedge clk); start_i = 1;
          @(negedge clk); start_i = 0;
          for (int k = 0; k < 40; k++) begin
            if (busy_o) busy_seen++;
            if (!scl_o) low_seen++;
            if (done_o) done_seen++;
            @(negedge clk);
          end
          check("R5 no busy on forbidden code", busy_seen, 0);
          check("R5 SCL held high", low_seen, 0);
          check("R5 no done", done_seen, 0);
        end else begin
          if (m == 1 && c == 5) begin per = 10; lo = 6; end
          else begin per = m ? c*4 : c*8; lo = per/2; end
          np = ae ? 9 : 8;
          run_byte();
          check("R11 no timeout", timed_out, 0);
          check(m ? (c == 5 ? "R4 low time" : "R3 low time") : "R2 low time", low1, lo);
          check(m ? (c == 5 ? "R4 high time" : "R3 high time") : "R2 high time", high1, per - lo);
          check("R6 pulse count", rises, np);
          check("R11 done latency", n, np*per);
          check("R7 tx never pulls SDA", slot_low + stray, 0);
          check("R7 ack without slot", got_ack, ae ? 1 : 1);
        end
      end
    end

    slot_case("R7 tx slave acks",    0, 0, 0, 0, 0, 0, 0);
    slot_case("R7 tx slave nacks",   0, 0, 0, 0, 1, 0, 1);
    slot_case("R8 rx data ack",      1, 0, 0, 0, 1, 1, 0);
    slot_case("R8 rx data no ack",   1, 0, 0, 1, 1, 0, 1);
    slot_case("R9 rx addr match",    1, 1, 1, 0, 1, 1, 0);
    slot_case("R9 rx addr mismatch", 1, 1, 0, 0, 1, 0, 1);
    slot_case("R9 rx addr match nack", 1, 1, 1, 1, 1, 0, 1);

    rx_mode = 0; slave_sda = 1;
    write_cfg(8'h85);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (30) @(negedge clk);
    check("R10 busy mid-byte", busy_o, 1);
    write_cfg(8'h85);
    check("R10 busy cleared", busy_o, 0);
    check("R10 scl high", scl_o, 1);
    begin
      int d = 0;
      for (int k = 0; k < 400; k++) begin
        if (done_o) d++;
        @(negedge clk);
      end
      check("R10 no done after abort", d, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule